// File: doc/BRIEF.md
# Duplicate-Free Lottery Number Draw Controller

This block picks lottery numbers one at a time from a fast free-running counter that cycles over 1 to MAX. An operator arms a new game with a start button. Each press of a draw button takes the counter's current value as the next number. That number is shown on a two-digit BCD output for a fixed display time, and then the counter starts running again.

Within one game no number can come out twice. A press that lands while the counter sits on an already-drawn value stays pending. The counter keeps stepping, and the first value that has not been used yet is captured. After a fixed number of draws the game is over, and draw presses do nothing until the next start.

Both buttons are asynchronous and active-low. Each one passes through a two-flop synchroniser, a falling-edge detector and a debounce lockout before the control logic sees it. MAX is derived from a two-digit parameter: 20 is added when that parameter is below 30.

Top module: `lotto_draw`

## Requirements
- R1: Every displayed number lies in 1..MAX and is never 0. It appears on `tens` and `units` as BCD digits (value = tens*10 + units, units in 0..9).
- R2: MAX equals the parameter ID_DIGITS when ID_DIGITS is 30 or more, and ID_DIGITS+20 otherwise. With ID_DIGITS=10, a full game of 30 draws yields exactly the numbers 1..30.
- R3: After reset, `tens`, `units`, `draws_done`, `draw_valid` and `game_over` are all 0, and no game is armed.
- R4: A draw press before the first start press captures nothing: `draw_valid` stays 0 and `draws_done` stays 0.
- R5: An accepted draw raises `draw_valid` for exactly CLK_HZ*HOLD_SECONDS cycles. The digits stay stable during that time, and `draws_done` goes up by one.
- R6: No number is drawn twice in a game. A press that arrives while the counter holds a used value waits until the counter reaches an unused value and captures that one.
- R7: When `draws_done` reaches NUM_DRAWS, `game_over` goes to 1. Later draw presses are ignored and `draws_done` keeps its value.
- R8: A start press clears the draw count, `game_over` and the record of used numbers, so numbers from an earlier game can be drawn again.
- R9: The buttons are active-low and pass through a two-flop synchroniser. One press is registered per falling edge, so holding a button low yields only one draw.
- R10: After any level change of a synchronised button, a falling edge within (CLK_HZ/1000)*DEBOUNCE_MS cycles is ignored as bounce.
- R11: A draw press while a number is being displayed is ignored and is not queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_n | input | 1 | Start button, asynchronous, active-low |
| draw_n | input | 1 | Draw button, asynchronous, active-low |
| tens | output | 4 | BCD tens digit of the last drawn number |
| units | output | 4 | BCD units digit of the last drawn number |
| draw_valid | output | 1 | High while a drawn number is being displayed |
| draws_done | output | DW | Count of numbers drawn in the current game |
| game_over | output | 1 | High once NUM_DRAWS numbers have been drawn |

## Verification
The assertions check several things on every cycle: the counter stays within 1..MAX, a shown value is in range with valid BCD, each capture sets exactly one new used bit and that bit belongs to the shown number, the digits hold still during display, the draw count never exceeds its limit, `game_over` agrees with the count, and a button pulse lasts a single cycle. Some behaviour can only be shown by the bench's scenarios: the exact display length, draws being ignored before start, during display and after the game ends, the debounce lockout against a fast re-press, the restart that frees earlier numbers, and a full game that covers every value in 1..MAX with no repeats.

// File: rtl/lotto_pkg.sv
package lotto_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_RUN,
        PH_SHOW,
        PH_OVER
    } phase_e;

    // Split a value of up to 99 into {tens, units} BCD digits.
    function automatic logic [7:0] to_bcd(input logic [6:0] v);
        logic [6:0] t;
        logic [6:0] u;
        t = v / 7'd10;
        u = v - t * 7'd10;
        return {t[3:0], u[3:0]};
    endfunction

endpackage

// File: rtl/lotto_button.sv
module lotto_button #(
    parameter int LOCK_CYC = 10,
    localparam int LW = $clog2(LOCK_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_n,
    output logic press
);

    logic s1_q, s2_q;

    typedef struct packed {
        logic          lvl;
        logic [LW-1:0] lock;
    } btn_t;

    btn_t cur_q, nxt_d;

    // Two-flop synchroniser; idle level of an active-low button is 1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
        end else begin
            s1_q <= btn_n;
            s2_q <= s1_q;
        end
    end

    always_comb begin
        nxt_d = cur_q;
        press = 1'b0;
        if (s2_q != cur_q.lvl) begin
            nxt_d.lvl  = s2_q;
            nxt_d.lock = LW'(LOCK_CYC);
            if (!s2_q && cur_q.lock == '0) begin
                press = 1'b1;
            end
        end else if (cur_q.lock != '0) begin
            nxt_d.lock = cur_q.lock - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{lvl: 1'b1, lock: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    // R9: one pulse per falling edge, never two cycles in a row
    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        press |=> !press);

endmodule

// File: rtl/lotto_counter.sv
module lotto_counter #(
    parameter int MAX_NUM = 45,
    localparam int VW = $clog2(MAX_NUM + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    output logic [VW-1:0] value
);

    logic [VW-1:0] value_d;

    always_comb begin
        value_d = value;
        if (run) begin
            value_d = (value == VW'(MAX_NUM)) ? VW'(1) : value + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= VW'(1);
        end else begin
            value <= value_d;
        end
    end

    // R1: the counter never leaves 1..MAX
    assert_count_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (value >= VW'(1)) && (value <= VW'(MAX_NUM)));

endmodule

// File: rtl/lotto_draw.sv
module lotto_draw
    import lotto_pkg::*;
#(
    parameter int ID_DIGITS    = 45,
    parameter int NUM_DRAWS    = 6,
    parameter int CLK_HZ       = 50_000_000,
    parameter int HOLD_SECONDS = 3,
    parameter int DEBOUNCE_MS  = 10,
    localparam int DW = $clog2(NUM_DRAWS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_n,
    input  logic          draw_n,
    output logic [3:0]    tens,
    output logic [3:0]    units,
    output logic          draw_valid,
    output logic [DW-1:0] draws_done,
    output logic          game_over
);

    localparam int MAX_NUM  = (ID_DIGITS < 30) ? ID_DIGITS + 20 : ID_DIGITS;
    localparam int VW       = $clog2(MAX_NUM + 1);
    localparam int HOLD_CYC = CLK_HZ * HOLD_SECONDS;
    localparam int HW       = $clog2(HOLD_CYC + 1);
    localparam int LOCK_RAW = (CLK_HZ / 1000) * DEBOUNCE_MS;
    localparam int LOCK_CYC = (LOCK_RAW < 1) ? 1 : LOCK_RAW;

    initial begin
        assert (NUM_DRAWS >= 1 && NUM_DRAWS <= MAX_NUM)
        else $error("NUM_DRAWS must lie in 1..MAX");
    end

    typedef struct packed {
        phase_e           phase;
        logic             pending;
        logic [MAX_NUM:1] used;
        logic [VW-1:0]    num;
        logic [HW-1:0]    hold;
        logic [DW-1:0]    done;
        logic             over;
    } ctl_t;

    ctl_t          ctl_q, ctl_d;
    logic          start_p, draw_p;
    logic          run;
    logic [VW-1:0] cnt;
    logic [7:0]    bcd;

    lotto_button #(.LOCK_CYC(LOCK_CYC)) u_start_btn (
        .clk(clk), .rst_n(rst_n), .btn_n(start_n), .press(start_p)
    );

    lotto_button #(.LOCK_CYC(LOCK_CYC)) u_draw_btn (
        .clk(clk), .rst_n(rst_n), .btn_n(draw_n), .press(draw_p)
    );

    // The counter freezes while a number is on display, then resumes.
    assign run = (ctl_q.phase != PH_SHOW);

    lotto_counter #(.MAX_NUM(MAX_NUM)) u_counter (
        .clk(clk), .rst_n(rst_n), .run(run), .value(cnt)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (start_p) begin
            ctl_d.phase   = PH_RUN;
            ctl_d.pending = 1'b0;
            ctl_d.used    = '0;
            ctl_d.done    = '0;
            ctl_d.over    = 1'b0;
        end else begin
            unique case (ctl_q.phase)
                PH_RUN: begin
                    if (draw_p) begin
                        ctl_d.pending = 1'b1;
                    end
                    // Capture only a value not yet drawn in this game.
                    if (ctl_q.pending && !ctl_q.used[cnt]) begin
                        ctl_d.used[cnt] = 1'b1;
                        ctl_d.num       = cnt;
                        ctl_d.hold      = HW'(HOLD_CYC - 1);
                        ctl_d.done      = ctl_q.done + 1'b1;
                        ctl_d.pending   = 1'b0;
                        ctl_d.phase     = PH_SHOW;
                        if (ctl_q.done + 1'b1 == DW'(NUM_DRAWS)) begin
                            ctl_d.over = 1'b1;
                        end
                    end
                end
                PH_SHOW: begin
                    if (ctl_q.hold == '0) begin
                        ctl_d.phase = ctl_q.over ? PH_OVER : PH_RUN;
                    end else begin
                        ctl_d.hold = ctl_q.hold - 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{phase: PH_IDLE, pending: 1'b0, used: '0, num: '0,
                       hold: '0, done: '0, over: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign bcd        = to_bcd(7'(ctl_q.num));
    assign tens       = bcd[7:4];
    assign units      = bcd[3:0];
    assign draw_valid = (ctl_q.phase == PH_SHOW);
    assign draws_done = ctl_q.done;
    assign game_over  = ctl_q.over;

    // R1: a shown value is in range with a legal units digit
    assert_shown_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        draw_valid |-> (ctl_q.num >= VW'(1)) && (ctl_q.num <= VW'(MAX_NUM)) && (units <= 4'd9));

    // R6: each capture sets exactly one new used bit, the one for the shown number
    assert_fresh_number_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(draw_valid) |->
            ($countones(ctl_q.used ^ $past(ctl_q.used)) == 1) && ctl_q.used[ctl_q.num]);

    // R5: digits hold still during a display
    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (draw_valid && $past(draw_valid)) |-> ($stable(tens) && $stable(units)));

    // R7: the count never passes the limit, and game over matches it
    assert_done_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (draws_done <= DW'(NUM_DRAWS)) && (game_over == (draws_done == DW'(NUM_DRAWS))));

    // R4: no draws happen while no game is armed
    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.phase == PH_IDLE) |-> (!draw_valid && draws_done == '0));

endmodule

// File: tb/lotto_draw_test.sv
`timescale 1ns/1ps
module lotto_draw_test;

    localparam int ID_DIGITS = 10;
    localparam int MAXV      = 30;
    localparam int NDRAW     = 30;
    localparam int HZ        = 1000;
    localparam int HOLD      = 1000;
    localparam int DW        = $clog2(NDRAW + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_n = 1'b1;
    logic          draw_n = 1'b1;
    logic [3:0]    tens, units;
    logic          draw_valid;
    logic [DW-1:0] draws_done;
    logic          game_over;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;
    bit  seen [1:MAXV];
    int  first_game [3];

    always #2 clk = ~clk;

    lotto_draw #(
        .ID_DIGITS(ID_DIGITS), .NUM_DRAWS(NDRAW), .CLK_HZ(HZ),
        .HOLD_SECONDS(1), .DEBOUNCE_MS(10)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start_n(start_n), .draw_n(draw_n),
        .tens(tens), .units(units), .draw_valid(draw_valid),
        .draws_done(draws_done), .game_over(game_over)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic press_start();
        @(negedge clk) start_n = 1'b0;
        repeat (15) @(negedge clk);
        start_n = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    // Press draw; report whether a number appeared, its value and display length.
    task automatic do_draw(input bit keep_low, input bit mid_press,
                           output bit got, output int val, output int hi);
        got = 0; val = 0; hi = 0;
        @(negedge clk) draw_n = 1'b0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (!keep_low && i == 15) draw_n = 1'b1;
            if (draw_valid) begin
                got = 1;
                break;
            end
        end
        if (got) begin
            val = tens * 10 + units;
            hi  = 1;
            for (int k = 0; k < 3 * HOLD; k++) begin
                @(negedge clk);
                if (!keep_low && hi == 20) draw_n = 1'b1;
                if (mid_press && hi == 500) draw_n = 1'b0;
                if (mid_press && hi == 515) draw_n = 1'b1;
                if (!draw_valid) break;
                hi++;
            end
        end
        if (!keep_low) draw_n = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tens == 0 && units == 0, "R3 digits after reset", tens * 10 + units, 0);
        chk(!draw_valid && !game_over, "R3 flags after reset", {draw_valid, game_over}, 0);
        chk(draws_done == 0, "R3 count after reset", draws_done, 0);
    endtask

    task automatic t_draw_before_start();
        bit got; int v, h;
        do_draw(0, 0, got, v, h);
        chk(!got, "R4 draw before start shows nothing", got, 0);
        chk(draws_done == 0, "R4 count before start", draws_done, 0);
    endtask

    task automatic t_show_ignores_press();
        bit got; int v, h;
        do_draw(0, 1, got, v, h);
        first_game[0] = v;
        chk(got && v >= 1 && v <= MAXV, "R1 first draw in range", v, 1);
        chk(h == HOLD, "R5 display length", h, HOLD);
        repeat (60) @(negedge clk);
        chk(!draw_valid, "R11 press during display not queued", draw_valid, 0);
        chk(draws_done == 1, "R11 count after display press", draws_done, 1);
    endtask

    task automatic t_held_and_bounce();
        bit got; int v, h;
        do_draw(1, 0, got, v, h);
        first_game[1] = v;
        chk(got && v != first_game[0], "R6 second draw differs", v, first_game[0]);
        repeat (50) @(negedge clk);
        chk(!draw_valid && draws_done == 2, "R9 held button draws once", draws_done, 2);
        draw_n = 1'b1;
        repeat (3) @(negedge clk);
        draw_n = 1'b0;
        repeat (80) @(negedge clk);
        chk(!draw_valid && draws_done == 2, "R10 bounce inside lockout ignored", draws_done, 2);
        draw_n = 1'b1;
        repeat (20) @(negedge clk);
        do_draw(0, 0, got, v, h);
        first_game[2] = v;
        chk(got && draws_done == 3, "R10 clean press after lockout accepted", draws_done, 3);
    endtask

    task automatic t_restart();
        press_start();
        chk(draws_done == 0 && !game_over && !draw_valid, "R8 start clears game", draws_done, 0);
    endtask

    task automatic t_full_game();
        bit got; int v, h;
        int bad_range = 0, repeats = 0, bad_hold = 0, misses = 0;
        for (int n = 1; n <= MAXV; n++) seen[n] = 0;
        for (int d = 0; d < NDRAW; d++) begin
            do_draw(0, 0, got, v, h);
            if (!got) misses++;
            else if (v < 1 || v > MAXV || units > 9) bad_range++;
            else begin
                if (seen[v]) repeats++;
                seen[v] = 1;
            end
            if (got && h != HOLD) bad_hold++;
            if (d == 0) chk(h == HOLD, "R5 display length new game", h, HOLD);
        end
        chk(misses == 0, "R5 every press drew", misses, 0);
        chk(bad_range == 0, "R1 all values in 1..MAX", bad_range, 0);
        chk(repeats == 0, "R6 no repeats in game", repeats, 0);
        chk(bad_hold == 0, "R5 all display lengths", bad_hold, 0);
        for (int n = 1; n <= MAXV; n++)
            chk(seen[n], "R2 value drawn in full game", n, 1);
        for (int j = 0; j < 3; j++)
            chk(seen[first_game[j]], "R8 earlier value drawn again", first_game[j], 1);
        chk(draws_done == NDRAW, "R7 count at end", draws_done, NDRAW);
        chk(game_over, "R7 game over raised", game_over, 1);
        do_draw(0, 0, got, v, h);
        chk(!got && draws_done == NDRAW, "R7 draw after game over ignored", draws_done, NDRAW);
        press_start();
        chk(!game_over && draws_done == 0, "R8 start after game over", game_over, 0);
    endtask

    initial begin
        t_reset();
        t_draw_before_start();
        press_start();
        t_show_ignores_press();
        t_held_and_bounce();
        t_restart();
        t_full_game();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule